// File: doc/BRIEF.md
# Four-Channel Pulse-Width Generator with APB Register Access

This block produces four independent pulse-width modulated outputs. Software sets each output through an APB slave port. Every channel has two 32-bit settings, both measured in cycles of the bus clock. The first is the on-time. The second is the length of one full waveform cycle. A running channel drives its pin high for the on-time at the start of each cycle and drives it low for the rest of that cycle, then starts the next cycle.

Settings written over the bus do not disturb a cycle that is already under way. Each channel keeps a working copy of its settings and a cycle counter. The working copy is reloaded from the programmed values only when the counter finishes a cycle, or at any clock edge while the channel is idle. A channel whose working cycle length is zero is idle, and its pin rests high. This is also the state after reset. Readback always returns the values last written, even when the working copy is still running on older values.

Top module: `pwm_bank_apb`

## Requirements
- R1: Channel c (0 to 3) holds a 32-bit on-time register at byte address c*8 and a 32-bit cycle-length register at byte address c*8+4. A read returns the value last written to that address.
- R2: After reset, all eight registers read 0 and all four outputs are high.
- R3: `pready` is 1 on every access, so every transfer finishes without wait states.
- R4: An address is unmapped if its two low bits are nonzero or if it is 0x20 or above. A read of an unmapped address returns 0. A write to an unmapped address changes no register and no output.
- R5: A running channel with on-time H and cycle length P, where 0 < H < P, drives its output high for H clocks and then low for P-H clocks, and repeats this pattern.
- R6: A running channel whose on-time is at least its nonzero cycle length holds its output high for the whole cycle.
- R7: A running channel with an on-time of 0 and a nonzero cycle length holds its output low for the whole cycle.
- R8: A write to a running channel reaches its output only after the cycle under way ends. Readback shows the new value at once.
- R9: A channel whose working cycle length is 0 is idle, and its output is high. Writing 0 to both registers of a running channel lets the current cycle finish, then makes the channel idle.
- R10: When an idle channel is given a nonzero cycle length, the write is registered on one clock edge. The first clock of the new cycle starts on the next edge.
- R11: Channels are independent. Programming one channel does not change the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the time base of the counters |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pwm_o | output | 4 | Channel outputs, bit c is channel c |

## Verification
The assertions check the following on every cycle:
- An idle channel is high.
- Saturated and zero on-times give a constant level.
- The counter stays inside the working cycle length.
- The working settings never change in the middle of a cycle.
- An idle channel given a nonzero length reloads on the next edge.

Only the bench scenarios can show the rest:
- the exact high/low pattern over several cycles;
- where the deferred update and the stop take effect, counted against the cycle boundary;
- readback and address decode, including unmapped and misaligned addresses;
- the isolation between channels.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
   // Which of the two per-channel words an address selects (address bit 2)
   typedef enum logic {
      FLD_ONTIME = 1'b0,
      FLD_CYCLE  = 1'b1
   } fld_e;

   // Byte stride between channels and the width of a register word
   localparam int unsigned CH_STRIDE_B = 8;
   localparam int unsigned WORD_B      = 4;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          psel,
   input  logic                          penable,
   input  logic                          pwrite,
   input  logic [ADDR_W-1:0]             paddr,
   input  logic [DATA_W-1:0]             pwdata,
   output logic [DATA_W-1:0]             prdata,
   output logic [NUM_CH-1:0][CNT_W-1:0]  cfg_hi,
   output logic [NUM_CH-1:0][CNT_W-1:0]  cfg_per
);
   localparam int unsigned CH_W = $clog2(NUM_CH);

   logic [ADDR_W-1:0] ch_full;
   logic [CH_W-1:0]   ch_idx;
   logic              hit;
   logic              wr_en;
   fld_e              fld;

   always_comb begin
      ch_full = paddr >> 3;
      ch_idx  = ch_full[CH_W-1:0];
      fld     = fld_e'(paddr[2]);
      hit     = (paddr[1:0] == 2'b00) && (ch_full < ADDR_W'(NUM_CH));
      wr_en   = psel && penable && pwrite && hit;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [CNT_W-1:0] hi_r;
      logic [CNT_W-1:0] per_r;
      logic             sel;

      assign sel = wr_en && (ch_idx == CH_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_r  <= '0;
            per_r <= '0;
         end else if (sel) begin
            if (fld == FLD_CYCLE) per_r <= pwdata[CNT_W-1:0];
            else                  hi_r  <= pwdata[CNT_W-1:0];
         end
      end

      assign cfg_hi[c]  = hi_r;
      assign cfg_per[c] = per_r;
   end

   always_comb begin
      prdata = '0;
      if (hit) begin
         if (fld == FLD_CYCLE) prdata = DATA_W'(cfg_per[ch_idx]);
         else                  prdata = DATA_W'(cfg_hi[ch_idx]);
      end
   end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_hi,
   input  logic [CNT_W-1:0] cfg_per,
   output logic [CNT_W-1:0] act_hi,
   output logic [CNT_W-1:0] act_per,
   output logic [CNT_W-1:0] cnt,
   output logic             pwm_o
);
   logic idle;
   logic last;

   always_comb begin
      idle  = (act_per == '0);
      last  = !idle && (cnt == act_per - CNT_W'(1));
      pwm_o = idle || (cnt < act_hi);
   end

   // Working copy reloads only at a cycle end or while idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_hi  <= '0;
         act_per <= '0;
         cnt     <= '0;
      end else if (idle || last) begin
         act_hi  <= cfg_hi;
         act_per <= cfg_per;
         cnt     <= '0;
      end else begin
         cnt     <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/pwm_bank_apb.sv
module pwm_bank_apb #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic [NUM_CH-1:0] pwm_o
);
   localparam int unsigned MAP_BYTES = NUM_CH * pwm_bank_pkg::CH_STRIDE_B;

   if (NUM_CH < 2) begin : g_bad_nch
      $error("NUM_CH must be at least 2");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie between 2 and DATA_W");
   end
   if ((1 << ADDR_W) < MAP_BYTES) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] cfg_hi;
   logic [NUM_CH-1:0][CNT_W-1:0] cfg_per;
   logic [NUM_CH-1:0][CNT_W-1:0] act_hi;
   logic [NUM_CH-1:0][CNT_W-1:0] act_per;
   logic [NUM_CH-1:0][CNT_W-1:0] cnt;

   assign pready = 1'b1;

   pwm_bank_regs #(
      .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .cfg_hi(cfg_hi), .cfg_per(cfg_per)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      pwm_bank_chan #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .cfg_hi(cfg_hi[c]), .cfg_per(cfg_per[c]),
         .act_hi(act_hi[c]), .act_per(act_per[c]), .cnt(cnt[c]),
         .pwm_o(pwm_o[c])
      );
   end
endmodule

// File: rtl/pwm_bank_apb_chk.sv
module pwm_bank_apb_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_CH-1:0]            pwm_o,
   input logic [NUM_CH-1:0][CNT_W-1:0] cfg_per,
   input logic [NUM_CH-1:0][CNT_W-1:0] act_hi,
   input logic [NUM_CH-1:0][CNT_W-1:0] act_per,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      // R9
      idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_per[c] == '0) |-> pwm_o[c]);
      // R5
      cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_per[c] != '0) |-> (cnt[c] < act_per[c]));
      // R6
      full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_per[c] != '0 && act_hi[c] >= act_per[c]) |-> pwm_o[c]);
      // R7
      full_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_per[c] != '0 && act_hi[c] == '0) |-> !pwm_o[c]);
      // R8
      hold_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_per[c] != '0 && cnt[c] != act_per[c] - CNT_W'(1))
         |=> ($stable(act_per[c]) && $stable(act_hi[c])));
      // R10
      start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_per[c] == '0 && cfg_per[c] != '0)
         |=> (cnt[c] == '0 && act_per[c] == $past(cfg_per[c])));
   end
endmodule

bind pwm_bank_apb pwm_bank_apb_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .cfg_per(cfg_per),
   .act_hi(act_hi), .act_per(act_per), .cnt(cnt)
);

// File: tb/sim_pwm_bank_apb.sv
module sim_pwm_bank_apb;
   localparam int NCH = 4;
   localparam int DW  = 32;
   localparam int AW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [DW-1:0] pwdata = '0;
   logic [DW-1:0] prdata;
   logic          pready;
   logic [NCH-1:0] pwm_o;

   int total = 0;
   int bad   = 0;
   int idx   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   pwm_bank_apb u0 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pwm_o(pwm_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      idx++;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      tick(); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      tick(); penable = 1'b1;
      tick(); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      tick(); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      tick(); penable = 1'b1;
      #1;
      d = prdata;
      check("R3", "pready", 32'(pready), 32'd1);
      tick(); psel = 1'b0; penable = 1'b0;
   endtask

   // Start an idle channel; index 0 is the first clock of its first cycle
   task automatic start(input int c, input logic [31:0] h, input logic [31:0] p);
      wr(AW'(c*8), h);
      wr(AW'(c*8+4), p);
      check("R10", "idle before start", 32'(pwm_o[c]), 32'd1);
      idx = -1;
   endtask

   task automatic trace(input string req, input int c, input int h, input int p,
                        input int from, input int upto);
      for (int i = from; i <= upto; i++) begin
         while (idx < i) tick();
         check(req, $sformatf("ch%0d idx%0d", c, i), 32'(pwm_o[c]),
               32'((i % p) < h));
      end
   endtask

   task automatic stop_all(input int waitn);
      for (int c = 0; c < NCH; c++) begin
         wr(AW'(c*8+4), 32'd0);
         wr(AW'(c*8), 32'd0);
      end
      repeat (waitn) tick();
      check("R9", "all idle high", 32'(pwm_o), 32'hF);
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      check("R2", "outputs after reset", 32'(pwm_o), 32'hF);
      for (int a = 0; a < 8; a++) begin
         rd(AW'(a*4), d);
         check("R2", $sformatf("reg %0h after reset", a*4), d, 32'd0);
      end
   endtask

   task automatic t_readback();
      logic [DW-1:0] d;
      for (int c = 0; c < NCH; c++) begin
         wr(AW'(c*8), 32'hA5A5_0000 + 32'(c));
         wr(AW'(c*8+4), 32'h20 + 32'(c));
      end
      for (int c = 0; c < NCH; c++) begin
         rd(AW'(c*8), d);
         check("R1", $sformatf("on-time ch%0d", c), d, 32'hA5A5_0000 + 32'(c));
         rd(AW'(c*8+4), d);
         check("R1", $sformatf("cycle ch%0d", c), d, 32'h20 + 32'(c));
      end
      stop_all(80);
   endtask

   task automatic t_unmapped();
      logic [DW-1:0] d;
      logic [AW-1:0] bad_a [4] = '{8'h20, 8'h24, 8'h02, 8'hFC};
      for (int k = 0; k < 4; k++) wr(bad_a[k], 32'hFFFF_FFFF);
      wr(8'h07, 32'h0000_0003);
      for (int k = 0; k < 4; k++) begin
         rd(bad_a[k], d);
         check("R4", $sformatf("unmapped %0h", bad_a[k]), d, 32'd0);
      end
      for (int a = 0; a < 8; a++) begin
         rd(AW'(a*4), d);
         check("R4", $sformatf("mapped %0h untouched", a*4), d, 32'd0);
      end
      check("R4", "outputs untouched", 32'(pwm_o), 32'hF);
   endtask

   task automatic t_basic();
      start(0, 2, 5);
      for (int i = 0; i <= 14; i++) begin
         trace("R5", 0, 2, 5, i, i);
         check("R11", "others idle", 32'(pwm_o[3:1]), 32'h7);
      end
      stop_all(20);
   endtask

   task automatic t_saturate();
      start(1, 9, 4);
      trace("R6", 1, 9, 4, 0, 11);
      wr(8'h08, 32'd0);                 // idx 14, registered after idx 13
      trace("R8", 1, 9, 4, 14, 15);     // old setting to the boundary
      trace("R7", 1, 0, 4, 16, 23);
      stop_all(20);
   endtask

   task automatic t_deferred();
      logic [DW-1:0] d;
      start(2, 20, 20);
      trace("R8", 2, 20, 20, 0, 4);
      wr(8'h10, 32'd0);                 // ends at idx 7
      rd(8'h10, d);                     // ends at idx 10
      check("R8", "readback new on-time", d, 32'd0);
      trace("R8", 2, 20, 20, 10, 19);
      trace("R8", 2, 0, 20, 20, 39);
      wr(8'h14, 32'd0);                 // ends at idx 42, cycle 40..59 runs
      trace("R9", 2, 0, 20, 42, 59);
      trace("R9", 2, 1, 1, 60, 65);
   endtask

   task automatic t_independent();
      start(3, 1, 3);
      start(2, 2, 5);                   // channel 3 is now 6 clocks ahead
      for (int i = 0; i <= 14; i++) begin
         trace("R11", 2, 2, 5, i, i);
         check("R11", $sformatf("ch3 idx%0d", i + 6), 32'(pwm_o[3]),
               32'(((i + 6) % 3) < 1));
         check("R11", "ch0/ch1 idle", 32'(pwm_o[1:0]), 32'h3);
      end
      stop_all(20);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_unmapped();
      t_readback();
      t_basic();
      t_saturate();
      t_deferred();
      t_independent();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule